// File: doc/BRIEF.md
# Single-Level Page Table Walker

This unit turns a 32-bit virtual address into a physical address using a flat page table that sits in a separate table memory. Pages are 4 KB. The upper 20 bits of the address are the virtual page number, and the lower 12 bits are the offset inside the page. The page number picks one 32-bit entry out of the table, and each virtual page has exactly one entry. The table starts at a byte address held in a base register. Software reloads that register when it switches from one process to another.

A request carries an address and an access kind. The unit then reads the entry and checks that it is valid and that it allows the requested kind of access. It answers with either a physical address or a fault code. When an access succeeds, the unit marks the entry as used, and also as dirty on a write. It writes the entry back to the table only if one of those two bits changed. The table port is a plain synchronous port: a read issued on one clock edge returns its data after that edge. The unit handles one request at a time and signals `busy` while it is working on it.

Entry layout:
- bit 31: dirty (modified)
- bit 30: used (referenced)
- bit 29: valid
- bits 28, 27, 26: read, write and execute permission
- bits 19:0: frame number
- all other bits: reserved as zero

Top module: `page_walker`

## Requirements
- R1: While `rst_n` is low and just after it is released, `busy`, `rsp_valid`, `mem_en` and `mem_we` are all 0.
- R2: A request is accepted when `req_valid` is high on a rising edge and `busy` is low. Exactly one table read is issued, in the cycle after acceptance, at address base + 4 × (vaddr[31:12]).
- R3: A successful access responds with `rsp_fault` = 0 and `rsp_paddr` = {entry[19:0], vaddr[11:0]}. For example, vaddr 0x7468 with entry 7 holding frame 0x2 gives 0x2468.
- R4: An entry whose valid bit (bit 29) is clear responds with `rsp_fault` = 1 and `rsp_paddr` = 0. This check takes priority over the permission check.
- R5: The access kind is encoded as 0 = read, 1 = write, 2 = execute. Each kind needs its own permission bit: bit 28 for read, bit 27 for write, bit 26 for execute. A missing permission, or kind 3, responds with `rsp_fault` = 2 and `rsp_paddr` = 0.
- R6: A successful access of any kind sets the used bit (bit 30). Only a write also sets the dirty bit (bit 31). All other entry bits are kept unchanged.
- R7: The entry is written back only when bit 30 or bit 31 actually changes. Nothing is written on a fault.
- R8: `rsp_valid` is high for exactly one cycle. That cycle is the third cycle after the acceptance edge when there is no write-back, and the fourth cycle when there is one.
- R9: `busy` is high from the cycle after acceptance through the response cycle. `req_valid` is ignored while `busy` is high.
- R10: `base_ld` loads `base_val` into the base register only while `busy` is low. A load attempted while busy leaves the base unchanged for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_ld | input | 1 | Load strobe for the table base register |
| base_val | input | 32 | New table base byte address |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| busy | output | 1 | Request in progress; new requests are ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address; 0 on a fault |
| rsp_fault | output | 2 | 0 = ok, 1 = invalid page, 2 = permission fault |
| mem_en | output | 1 | Table memory access enable |
| mem_we | output | 1 | Table memory write enable |
| mem_addr | output | 32 | Table memory byte address |
| mem_wdata | output | 32 | Entry written back |
| mem_rdata | input | 32 | Entry read, valid in the cycle after the read |

## Verification
The bench starts with a set of directed cases:
- the 0x7468 → 0x2468 example;
- a repeated read of the same page, which must skip the write-back once the used bit is already set;
- a write to a read-only page;
- an invalid page that has every permission bit set, which shows that the valid check comes first;
- the unused kind 3;
- a second request and a base load that both arrive while the unit is busy.

After that, random entries and addresses, with random kinds and two table bases, cover all combinations of the valid, permission, used and dirty bits. Each response is compared against a bench model on five points: fault code, address, response latency, which table address was read, and whether the entry changed in table memory. Together these tell apart a wrong field decode, a wrong priority between the two faults, a write-back that is missing or unnecessary, and a base register that was updated at the wrong time.

// File: rtl/page_walker.sv
module page_walker #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_ld,
  input  logic [AW-1:0] base_val,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_kind,
  output logic          busy,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic [1:0]    rsp_fault,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int VPN_W = AW - OFF_W;
  localparam int B_DIRTY = 31;
  localparam int B_USED  = 30;
  localparam int B_VALID = 29;
  localparam int B_RD    = 28;
  localparam int B_WR    = 27;
  localparam int B_EX    = 26;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CHECK, S_WB, S_DONE} state_t;

  state_t        state;
  logic [AW-1:0] base_q;
  logic [AW-1:0] va_q;
  logic [1:0]    kind_q;
  logic [31:0]   pte_q;
  logic          allow;
  logic [1:0]    fault;
  logic [31:0]   pte_new;

  always_comb begin
    case (kind_q)
      2'd0:    allow = mem_rdata[B_RD];
      2'd1:    allow = mem_rdata[B_WR];
      2'd2:    allow = mem_rdata[B_EX];
      default: allow = 1'b0;
    endcase
    if (!mem_rdata[B_VALID]) fault = 2'd1;
    else if (!allow)         fault = 2'd2;
    else                     fault = 2'd0;
    pte_new = mem_rdata;
    pte_new[B_USED] = 1'b1;
    if (kind_q == 2'd1) pte_new[B_DIRTY] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      base_q    <= '0;
      va_q      <= '0;
      kind_q    <= '0;
      pte_q     <= '0;
      rsp_paddr <= '0;
      rsp_fault <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (base_ld) base_q <= base_val;
          if (req_valid) begin
            va_q   <= req_vaddr;
            kind_q <= req_kind;
            state  <= S_READ;
          end
        end
        S_READ: state <= S_CHECK;
        S_CHECK: begin
          pte_q     <= pte_new;
          rsp_fault <= fault;
          rsp_paddr <= (fault == 2'd0) ? {mem_rdata[PFN_W-1:0], va_q[OFF_W-1:0]} : '0;
          state     <= (fault == 2'd0 && pte_new != mem_rdata) ? S_WB : S_DONE;
        end
        S_WB:    state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = state != S_IDLE;
  assign rsp_valid = state == S_DONE;
  assign mem_en    = state == S_READ || state == S_WB;
  assign mem_we    = state == S_WB;
  assign mem_addr  = base_q + {{(AW-VPN_W-2){1'b0}}, va_q[AW-1:OFF_W], 2'b00};
  assign mem_wdata = pte_q;
endmodule

module page_walker_chk #(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_paddr,
  input logic [1:0]    rsp_fault,
  input logic          mem_en,
  input logic          mem_we,
  input logic [31:0]   mem_wdata,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] va_q
);
  assert_we_has_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);
  assert_wb_marks_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[30] && mem_wdata[29]));
  assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);
  assert_fault_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'd3);
  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);
  assert_one_cycle_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_busy_on_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);
  assert_base_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(base_q));
  assert_no_we_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
endmodule

bind page_walker page_walker_chk #(.AW(AW), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_en(mem_en),
  .mem_we(mem_we), .mem_wdata(mem_wdata), .base_q(base_q), .va_q(va_q)
);

// File: tb/sim_page_walker.sv
module sim_page_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        base_ld = 0;
  logic [31:0] base_val = 0;
  logic        req_valid = 0;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic        busy, rsp_valid, mem_en, mem_we;
  logic [31:0] rsp_paddr, mem_addr, mem_wdata;
  logic [1:0]  rsp_fault;
  logic [31:0] mem_rdata = 0;

  logic [31:0] tbl [0:1023];
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd = 0;
  logic [31:0] cur_base = 0;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  page_walker u0 (
    .clk(clk), .rst_n(rst_n), .base_ld(base_ld), .base_val(base_val),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        tbl[mem_addr[11:2]] <= mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata <= tbl[mem_addr[11:2]];
        last_rd   <= mem_addr;
        rd_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(input logic [31:0] p, input logic [1:0] k);
    logic al;
    al = (k == 0) ? p[28] : (k == 1) ? p[27] : (k == 2) ? p[26] : 1'b0;
    if (!p[29]) return 2'd1;
    if (!al)    return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [31:0] exp_pte(input logic [31:0] p, input logic [1:0] k);
    logic [31:0] n;
    n = p;
    if (exp_fault(p, k) == 0) begin
      n[30] = 1'b1;
      if (k == 1) n[31] = 1'b1;
    end
    return n;
  endfunction

  task automatic load_base(input logic [31:0] v);
    @(negedge clk); base_ld = 1; base_val = v;
    @(negedge clk); base_ld = 0;
    cur_base = v;
  endtask

  task automatic run(input logic [1:0] k, input logic [31:0] va, input bit poke);
    logic [31:0] a, pre, npte, ep;
    logic [1:0]  ef;
    bit          wb;
    int          rc0, wc0, n;
    a    = cur_base + {va[31:12], 2'b00};
    pre  = tbl[a[11:2]];
    ef   = exp_fault(pre, k);
    npte = exp_pte(pre, k);
    wb   = npte != pre;
    ep   = (ef == 0) ? {pre[19:0], va[11:0]} : 32'd0;
    rc0 = rd_cnt; wc0 = wr_cnt;
    @(negedge clk); req_valid = 1; req_vaddr = va; req_kind = k;
    @(negedge clk); req_valid = 0;
    n = 1;
    chk(busy === 1'b1, "R9 busy after accept", {31'd0, busy}, 1);
    if (poke) begin
      req_valid = 1; req_vaddr = va ^ 32'h0000_5000; req_kind = 2'd0;
      base_ld = 1; base_val = cur_base ^ 32'h0000_0400;
    end
    while (rsp_valid !== 1'b1 && n < 10) begin
      @(negedge clk); n++;
      if (poke && n == 2) begin req_valid = 0; base_ld = 0; end
    end
    chk(rsp_fault === ef, "R4/R5 fault code", {30'd0, rsp_fault}, {30'd0, ef});
    chk(rsp_paddr === ep, "R3 physical address", rsp_paddr, ep);
    chk(n == (wb ? 4 : 3), "R8 latency", n, wb ? 4 : 3);
    chk(rd_cnt - rc0 == 1 && last_rd === a, "R2 table read address", last_rd, a);
    chk(wr_cnt - wc0 == (wb ? 1 : 0), "R7 write-back count", wr_cnt - wc0, wb ? 1 : 0);
    chk(tbl[a[11:2]] === npte, "R6 entry after access", tbl[a[11:2]], npte);
    @(negedge clk);
    chk(rsp_valid === 1'b0 && busy === 1'b0, "R8/R9 response single cycle",
        {30'd0, rsp_valid, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) tbl[i] = 0;
    repeat (3) @(negedge clk);
    chk(busy === 0 && rsp_valid === 0 && mem_en === 0 && mem_we === 0, "R1 reset state",
        {28'd0, busy, rsp_valid, mem_en, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && rsp_valid === 0 && mem_en === 0, "R1 after release",
        {29'd0, busy, rsp_valid, mem_en}, 0);

    load_base(32'h0);
    tbl[7] = 32'h3000_0002;
    run(2'd0, 32'h0000_7468, 0);
    chk(tbl[7] === 32'h7000_0002, "R6 read sets used only", tbl[7], 32'h7000_0002);
    run(2'd0, 32'h0000_7468, 0);
    run(2'd1, 32'h0000_7010, 0);
    tbl[9] = 32'h1C00_0055;
    run(2'd0, 32'h0000_9abc, 0);
    tbl[10] = 32'h2400_0033;
    run(2'd2, 32'h0000_a004, 0);
    run(2'd3, 32'h0000_a004, 0);
    tbl[11] = 32'h3800_0044;
    run(2'd1, 32'h0000_b123, 0);
    run(2'd1, 32'h0000_b124, 0);
    tbl[12] = 32'h2000_0001;
    run(2'd0, 32'h0000_c000, 1);
    run(2'd0, 32'h0000_7468, 0);
    chk(last_rd === 32'h0000_001C, "R10 base kept after busy load", last_rd, 32'h1C);

    for (int i = 0; i < 512; i++) tbl[i + 512] = $urandom & 32'hFC0F_FFFF;
    for (int i = 0; i < 256; i++) tbl[i] = $urandom & 32'hFC0F_FFFF;
    for (int it = 0; it < 400; it++) begin
      if (it % 50 == 0) load_base(($urandom & 1) ? 32'h800 : 32'h0);
      run(2'($urandom), {12'($urandom), 8'($urandom), 12'($urandom)} & 32'h000F_FFFF, (it % 37) == 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule